// File: doc/BRIEF.md
# Coprocessor Access Permission Checker

This block sits beside the instruction pipeline and rules on every coprocessor register transfer, in either direction. The request gives the target coprocessor number, whether the core is in a privileged mode, and the CRn, CRm and opcode_2 fields. In the same cycle the block answers with either a grant or an undefined-instruction exception request, never both.

Coprocessors 0 to 13 are gated by a software-writable permission word that has one bit per coprocessor. It resets to all zeros, so an operating system can leave every shared unit locked and unlock one only when an application first touches it, after which the retried instruction completes. Coprocessors 14 and 15 ignore the permission word and only admit privileged code.

On coprocessor 15 the block also decodes the register fields into a one-hot select. It owns plain 32-bit storage for the permission word, the process-ID register and five debug breakpoint registers. A write to the process-ID register pulses a branch-target-buffer invalidate. A granted read returns its value one cycle later.

Top module: `cp_access_gate`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the permission word, every owned register and rd_data are zero, so every access to coprocessors 0 to 13 is refused.
- R2: A request to coprocessor n in 0..13 is granted when bit n of the permission word is 1 and refused with undef when it is 0, whatever the privilege input.
- R3: A request to coprocessor 14 or 15 with req_priv = 0 raises undef whatever the permission word holds. A privileged request to coprocessor 14 is always granted and selects no owned register.
- R4: The permission word sits on coprocessor 15 at CRn = 15, CRm = 1, opcode_2 = 0 (reg_sel bit 0). A write keeps data bits 13:0, and bits 31:14 always read back as zero.
- R5: The debug registers sit on coprocessor 15 at CRn = 14, opcode_2 = 0, with CRm = 8 for instruction breakpoint 0 (reg_sel bit 2), CRm = 9 for instruction breakpoint 1 (bit 3), CRm = 0 for data breakpoint address (bit 4), CRm = 3 for data mask/address (bit 5) and CRm = 4 for data breakpoint control (bit 6). Each stores and returns a full 32-bit word.
- R6: The process-ID register sits on coprocessor 15 at CRn = 13, CRm = 0, opcode_2 = 0 (reg_sel bit 1). A granted write to it drives btb_inval high in the same cycle as the request. No other request raises btb_inval.
- R7: A privileged coprocessor 15 request whose CRn/CRm/opcode_2 match none of the encodings in R4 to R6 raises undef.
- R8: grant and undef are combinational from the request, are never high together, and are both low when req_valid is low. A request that raises undef changes no register and leaves rd_data unchanged.
- R9: rd_data takes the selected register's value on the clock edge that ends a granted read, and holds otherwise. A granted read that selects no owned register (coprocessors 0 to 14) returns zero.
- R10: reg_sel is one-hot or zero. It is nonzero only during a granted coprocessor 15 request.
- R11: Once software sets a coprocessor's permission bit, a retry of the previously refused instruction is granted. Clearing the bit refuses it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A coprocessor transfer is presented this cycle |
| req_write | input | 1 | 1 = move to coprocessor (write), 0 = read |
| req_cp | input | 4 | Target coprocessor number |
| req_priv | input | 1 | 1 = core is in a privileged mode |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | opcode_2 field |
| req_wdata | input | 32 | Write data |
| grant | output | 1 | Transfer may execute |
| undef | output | 1 | Undefined-instruction exception request |
| reg_sel | output | 7 | One-hot select of the owned register being accessed |
| btb_inval | output | 1 | Branch-target-buffer invalidate pulse |
| rd_data | output | 32 | Read data, valid the cycle after a granted read |

## Verification
The assertions assume that every request field is driven to a known value, and that req_valid stays low while rst_n is low. They compare the process-ID value against the invalidate pulse of the previous cycle, which holds only because each request lasts exactly one cycle. The bench drives all inputs at the falling edge, raises req_valid for a single cycle per operation and clears it before the next one, and keeps every field defined during reset. Refused requests deliberately carry write data and mode combinations that would corrupt state if they leaked through, so the read-backs that follow show that nothing was written.

// File: rtl/cpag_pkg.sv
// Shared constants and types for the coprocessor access gate.
// Assumes the CRn/CRm/opcode_2 field widths of the instruction encoding
// (4, 4 and 3 bits) and a fixed set of seven owned registers.
package cpag_pkg;

    localparam int CRN_W = 4;
    localparam int CRM_W = 4;
    localparam int OP2_W = 3;

    // Owned register indices; the index is also the reg_sel bit position.
    localparam int SEL_N     = 7;
    localparam int SEL_CPACC = 0;
    localparam int SEL_PID   = 1;
    localparam int SEL_IBP0  = 2;
    localparam int SEL_IBP1  = 3;
    localparam int SEL_DBA   = 4;
    localparam int SEL_DMSK  = 5;
    localparam int SEL_DCTL  = 6;

    typedef struct packed {
        logic [CRN_W-1:0] crn;
        logic [CRM_W-1:0] crm;
        logic [OP2_W-1:0] op2;
    } reg_code_t;

    // Field encoding of each owned register on the system coprocessor.
    function automatic reg_code_t code_of(input int idx);
        reg_code_t c;
        case (idx)
            SEL_CPACC: c = '{crn: 4'd15, crm: 4'd1, op2: 3'd0};
            SEL_PID:   c = '{crn: 4'd13, crm: 4'd0, op2: 3'd0};
            SEL_IBP0:  c = '{crn: 4'd14, crm: 4'd8, op2: 3'd0};
            SEL_IBP1:  c = '{crn: 4'd14, crm: 4'd9, op2: 3'd0};
            SEL_DBA:   c = '{crn: 4'd14, crm: 4'd0, op2: 3'd0};
            SEL_DMSK:  c = '{crn: 4'd14, crm: 4'd3, op2: 3'd0};
            default:   c = '{crn: 4'd14, crm: 4'd4, op2: 3'd0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cpag_decode.sv
// Field decoder: compares CRn/CRm/opcode_2 against every owned register
// encoding and returns a hit vector. Assumes the encodings in the package
// are distinct, so at most one bit is set. Does not look at the coprocessor
// number; the caller qualifies the result.
module cpag_decode
    import cpag_pkg::*;
(
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output logic [SEL_N-1:0] hit_vec
);

    for (genvar i = 0; i < SEL_N; i++) begin : g_code
        localparam reg_code_t CODE = code_of(i);
        // Match one register encoding.
        assign hit_vec[i] = (crn == CODE.crn) && (crm == CODE.crm) && (op2 == CODE.op2);
    end

endmodule

// File: rtl/cpag_perm.sv
// Permission rule: decides whether a transfer to req_cp may run.
// Gated coprocessors (below DBG_CP) follow their permission bit regardless
// of mode; the debug and system coprocessors need privilege, and the system
// coprocessor also needs an implemented register encoding (sys_hit).
// Assumes DBG_CP < SYS_CP < NUM_CP and NUM_CP is a power of two.
module cpag_perm #(
    parameter  int NUM_CP = 16,
    parameter  int SYS_CP = 15,
    parameter  int DBG_CP = 14,
    localparam int CP_W   = $clog2(NUM_CP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CP_W-1:0]   req_cp,
    input  logic              req_priv,
    input  logic [NUM_CP-1:0] cpacc_bits,
    input  logic              sys_hit,
    output logic              allow
);

    // Combinational permission decision.
    always_comb begin
        allow = 1'b0;
        if (req_cp == CP_W'(SYS_CP)) begin
            allow = req_priv && sys_hit;
        end else if (req_cp == CP_W'(DBG_CP)) begin
            allow = req_priv;
        end else if (int'(req_cp) < DBG_CP) begin
            allow = cpacc_bits[req_cp];
        end
    end

    // R3: user mode never reaches the debug or system coprocessor.
    assert_user_sys_denied_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_priv && (int'(req_cp) >= DBG_CP)) |-> !allow);

endmodule

// File: rtl/cpag_regfile.sv
// Owned register storage: one DATA_W register per select bit, written when
// its wr_sel bit is high, plus a registered read port. The permission word
// keeps only the bits of gated coprocessors. Assumes wr_sel and rd_sel are
// one-hot or zero and DBG_CP <= NUM_CP <= DATA_W.
module cpag_regfile
    import cpag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CP = 16,
    parameter int DBG_CP = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_N-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [SEL_N-1:0]  rd_sel,
    output logic [NUM_CP-1:0] cpacc_bits,
    output logic [DATA_W-1:0] pid_value,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] GATE_MASK = DATA_W'((64'd1 << DBG_CP) - 64'd1);

    logic [SEL_N-1:0][DATA_W-1:0] regs_w;
    logic [DATA_W-1:0]            rd_mux;

    for (genvar i = 0; i < SEL_N; i++) begin : g_reg
        localparam logic [DATA_W-1:0] KEEP = (i == SEL_CPACC) ? GATE_MASK : '1;
        logic [DATA_W-1:0] q;
        // Hold one owned register; load masked write data when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_sel[i]) begin
                q <= wdata & KEEP;
            end
        end
        assign regs_w[i] = q;
    end

    // Read multiplexer, zero when nothing is selected.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < SEL_N; i++) begin
            if (rd_sel[i]) begin
                rd_mux = rd_mux | regs_w[i];
            end
        end
    end

    // Registered read port, updated only on a granted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    assign cpacc_bits = regs_w[SEL_CPACC][NUM_CP-1:0];
    assign pid_value  = regs_w[SEL_PID];

    // R10: at most one owned register written per cycle.
    assert_wsel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R4: the kept permission bits never include debug/system positions.
    assert_cpacc_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_w[SEL_CPACC] & ~GATE_MASK) == '0);

endmodule

// File: rtl/cp_access_gate.sv
// Coprocessor access gate top. Combines the field decoder, the permission
// rule and the owned register storage. grant/undef/reg_sel/btb_inval are
// combinational from the request; rd_data is registered. Assumes one
// request per req_valid cycle with all fields defined, and no request
// while rst_n is low.
module cp_access_gate
    import cpag_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int NUM_CP = 16,
    parameter  int SYS_CP = 15,
    parameter  int DBG_CP = 14,
    localparam int CP_W   = $clog2(NUM_CP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CP_W-1:0]   req_cp,
    input  logic              req_priv,
    input  logic [CRN_W-1:0]  req_crn,
    input  logic [CRM_W-1:0]  req_crm,
    input  logic [OP2_W-1:0]  req_op2,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              grant,
    output logic              undef,
    output logic [SEL_N-1:0]  reg_sel,
    output logic              btb_inval,
    output logic [DATA_W-1:0] rd_data
);

    logic [SEL_N-1:0]  hit_vec;
    logic [SEL_N-1:0]  sys_sel;
    logic [SEL_N-1:0]  wr_sel;
    logic              sys_hit;
    logic              allow;
    logic              rd_en;
    logic [NUM_CP-1:0] cpacc_bits;
    logic [DATA_W-1:0] pid_value;

    cpag_decode u_decode (
        .crn     (req_crn),
        .crm     (req_crm),
        .op2     (req_op2),
        .hit_vec (hit_vec)
    );

    // Decoder hits count only on the system coprocessor.
    assign sys_sel = (req_cp == CP_W'(SYS_CP)) ? hit_vec : '0;
    assign sys_hit = |sys_sel;

    cpag_perm #(
        .NUM_CP (NUM_CP),
        .SYS_CP (SYS_CP),
        .DBG_CP (DBG_CP)
    ) u_perm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_cp     (req_cp),
        .req_priv   (req_priv),
        .cpacc_bits (cpacc_bits),
        .sys_hit    (sys_hit),
        .allow      (allow)
    );

    // Outcome and register strobes for this request.
    assign grant     = req_valid && allow;
    assign undef     = req_valid && !allow;
    assign reg_sel   = grant ? sys_sel : '0;
    assign wr_sel    = (grant && req_write) ? sys_sel : '0;
    assign rd_en     = grant && !req_write;
    assign btb_inval = wr_sel[SEL_PID];

    cpag_regfile #(
        .DATA_W (DATA_W),
        .NUM_CP (NUM_CP),
        .DBG_CP (DBG_CP)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .wdata      (req_wdata),
        .rd_en      (rd_en),
        .rd_sel     (reg_sel),
        .cpacc_bits (cpacc_bits),
        .pid_value  (pid_value),
        .rd_data    (rd_data)
    );

    // R2: a cleared permission bit on a gated coprocessor forces undef.
    assert_gated_denied_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (int'(req_cp) < DBG_CP) && !cpacc_bits[req_cp]) |-> undef);

    // R8: a refused request leaves the permission word and read data alone.
    assert_undef_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        undef |=> ($stable(cpacc_bits) && $stable(rd_data) && $stable(pid_value)));

    // R6: the process-ID value only moves after an invalidate pulse.
    assert_pid_btb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pid_value) |-> $past(btb_inval));

    // R10: the select is one-hot or zero, and only on a granted system request.
    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_sel));
    assert_sel_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_sel) |-> (grant && (req_cp == CP_W'(SYS_CP)) && req_priv));

    // R9: reading the permission word returns it one cycle later.
    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !req_write && reg_sel[SEL_CPACC]) |=> (rd_data == DATA_W'($past(cpacc_bits))));

endmodule

// File: tb/tb_cp_access_gate.sv
`timescale 1ns/1ps
module tb_cp_access_gate;

    typedef struct packed {
        logic        wr;
        logic [3:0]  cp;
        logic        priv;
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic [31:0] wd;
        logic        eg;
        logic        eu;
        logic [6:0]  esel;
        logic        eb;
        logic        chk;
        logic [31:0] erd;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 31;
    // wr cp priv crn crm op2 wdata | grant undef sel btb chkrd rd | req
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd15, 1'b1, 4'd15, 4'd1, 3'd0, 32'h0,         1'b1, 1'b0, 7'h01, 1'b0, 1'b1, 32'h0,        8'd4},  // R4 read word
        '{1'b0, 4'd3,  1'b1, 4'd0,  4'd0, 3'd0, 32'h0,         1'b0, 1'b1, 7'h00, 1'b0, 1'b1, 32'h0,        8'd2},  // R2 denied
        '{1'b1, 4'd15, 1'b0, 4'd15, 4'd1, 3'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd3},  // R3 user write
        '{1'b0, 4'd15, 1'b1, 4'd15, 4'd1, 3'd0, 32'h0,         1'b1, 1'b0, 7'h01, 1'b0, 1'b1, 32'h0,        8'd8},  // R8 untouched
        '{1'b1, 4'd15, 1'b1, 4'd15, 4'd1, 3'd0, 32'hFFFF_0008, 1'b1, 1'b0, 7'h01, 1'b0, 1'b0, 32'h0,        8'd4},  // R4 write
        '{1'b0, 4'd15, 1'b1, 4'd15, 4'd1, 3'd0, 32'h0,         1'b1, 1'b0, 7'h01, 1'b0, 1'b1, 32'h0000_0008, 8'd4}, // R4 masked
        '{1'b0, 4'd3,  1'b0, 4'd7,  4'd2, 3'd5, 32'h0,         1'b1, 1'b0, 7'h00, 1'b0, 1'b1, 32'h0,        8'd11}, // R11 retry, R9 zero
        '{1'b0, 4'd4,  1'b1, 4'd0,  4'd0, 3'd0, 32'h0,         1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd2},  // R2
        '{1'b0, 4'd14, 1'b0, 4'd0,  4'd0, 3'd0, 32'h0,         1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd3},  // R3 user cp14
        '{1'b0, 4'd14, 1'b1, 4'd0,  4'd0, 3'd0, 32'h0,         1'b1, 1'b0, 7'h00, 1'b0, 1'b1, 32'h0,        8'd3},  // R3 priv cp14
        '{1'b1, 4'd15, 1'b1, 4'd14, 4'd8, 3'd0, 32'h1234_5678, 1'b1, 1'b0, 7'h04, 1'b0, 1'b0, 32'h0,        8'd5},  // R5
        '{1'b1, 4'd15, 1'b1, 4'd14, 4'd9, 3'd0, 32'hAAAA_5555, 1'b1, 1'b0, 7'h08, 1'b0, 1'b0, 32'h0,        8'd5},
        '{1'b1, 4'd15, 1'b1, 4'd14, 4'd0, 3'd0, 32'h0BAD_F00D, 1'b1, 1'b0, 7'h10, 1'b0, 1'b0, 32'h0,        8'd5},
        '{1'b1, 4'd15, 1'b1, 4'd14, 4'd3, 3'd0, 32'h0000_FFF0, 1'b1, 1'b0, 7'h20, 1'b0, 1'b0, 32'h0,        8'd5},
        '{1'b1, 4'd15, 1'b1, 4'd14, 4'd4, 3'd0, 32'h0000_0103, 1'b1, 1'b0, 7'h40, 1'b0, 1'b0, 32'h0,        8'd5},
        '{1'b0, 4'd15, 1'b1, 4'd14, 4'd8, 3'd0, 32'h0,         1'b1, 1'b0, 7'h04, 1'b0, 1'b1, 32'h1234_5678, 8'd5},
        '{1'b0, 4'd15, 1'b1, 4'd14, 4'd9, 3'd0, 32'h0,         1'b1, 1'b0, 7'h08, 1'b0, 1'b1, 32'hAAAA_5555, 8'd5},
        '{1'b0, 4'd15, 1'b1, 4'd14, 4'd0, 3'd0, 32'h0,         1'b1, 1'b0, 7'h10, 1'b0, 1'b1, 32'h0BAD_F00D, 8'd5},
        '{1'b0, 4'd15, 1'b1, 4'd14, 4'd3, 3'd0, 32'h0,         1'b1, 1'b0, 7'h20, 1'b0, 1'b1, 32'h0000_FFF0, 8'd5},
        '{1'b0, 4'd15, 1'b1, 4'd14, 4'd4, 3'd0, 32'h0,         1'b1, 1'b0, 7'h40, 1'b0, 1'b1, 32'h0000_0103, 8'd5},
        '{1'b0, 4'd15, 1'b0, 4'd14, 4'd8, 3'd0, 32'h0,         1'b0, 1'b1, 7'h00, 1'b0, 1'b1, 32'h0000_0103, 8'd8},  // R8 rd holds
        '{1'b1, 4'd15, 1'b1, 4'd13, 4'd0, 3'd0, 32'h0200_0000, 1'b1, 1'b0, 7'h02, 1'b1, 1'b0, 32'h0,        8'd6},  // R6 pulse
        '{1'b0, 4'd15, 1'b1, 4'd13, 4'd0, 3'd0, 32'h0,         1'b1, 1'b0, 7'h02, 1'b0, 1'b1, 32'h0200_0000, 8'd6}, // R6 read no pulse
        '{1'b1, 4'd15, 1'b1, 4'd14, 4'd5, 3'd0, 32'hDEAD_BEEF, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd7},  // R7
        '{1'b1, 4'd15, 1'b1, 4'd14, 4'd8, 3'd1, 32'hDEAD_BEEF, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd7},  // R7 op2
        '{1'b1, 4'd15, 1'b1, 4'd2,  4'd0, 3'd0, 32'hDEAD_BEEF, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd7},  // R7 crn
        '{1'b0, 4'd15, 1'b1, 4'd14, 4'd8, 3'd0, 32'h0,         1'b1, 1'b0, 7'h04, 1'b0, 1'b1, 32'h1234_5678, 8'd8}, // R8 no write
        '{1'b1, 4'd15, 1'b0, 4'd13, 4'd0, 3'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd6},  // R6 user: no pulse
        '{1'b0, 4'd15, 1'b1, 4'd13, 4'd0, 3'd0, 32'h0,         1'b1, 1'b0, 7'h02, 1'b0, 1'b1, 32'h0200_0000, 8'd6},
        '{1'b1, 4'd15, 1'b1, 4'd15, 4'd1, 3'd0, 32'h0,         1'b1, 1'b0, 7'h01, 1'b0, 1'b0, 32'h0,        8'd11}, // R11 clear
        '{1'b0, 4'd3,  1'b0, 4'd0,  4'd0, 3'd0, 32'h0,         1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0,        8'd11}  // R11 refused again
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_priv;
    logic [3:0]  req_cp, req_crn, req_crm;
    logic [2:0]  req_op2;
    logic [31:0] req_wdata;
    logic        grant, undef, btb_inval;
    logic [6:0]  reg_sel;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cp_access_gate dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cp    (req_cp),
        .req_priv  (req_priv),
        .req_crn   (req_crn),
        .req_crm   (req_crm),
        .req_op2   (req_op2),
        .req_wdata (req_wdata),
        .grant     (grant),
        .undef     (undef),
        .reg_sel   (reg_sel),
        .btb_inval (btb_inval),
        .rd_data   (rd_data)
    );

    task automatic check_rd(input logic [31:0] exp, input int rq);
        n_checks++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL R%0d rd_data actual %h expected %h", rq, rd_data, exp);
        end
    endtask

    task automatic check_resp(input logic eg, input logic eu, input logic [6:0] es,
                              input logic eb, input int rq);
        n_checks++;
        if (grant !== eg || undef !== eu || reg_sel !== es || btb_inval !== eb) begin
            n_fail++;
            $display("FAIL R%0d grant/undef/sel/btb actual %b/%b/%h/%b expected %b/%b/%h/%b",
                     rq, grant, undef, reg_sel, btb_inval, eg, eu, es, eb);
        end
    endtask

    // One request: called at a falling edge, returns at the next falling edge.
    task automatic run_op(input vec_t v);
        req_valid = 1'b1;
        req_write = v.wr;
        req_cp    = v.cp;
        req_priv  = v.priv;
        req_crn   = v.crn;
        req_crm   = v.crm;
        req_op2   = v.op2;
        req_wdata = v.wd;
        #1;
        check_resp(v.eg, v.eu, v.esel, v.eb, int'(v.rq));
        @(negedge clk);
        if (v.chk) check_rd(v.erd, int'(v.rq));
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_priv = 1'b0;
        req_cp = 4'd0; req_crn = 4'd0; req_crm = 4'd0; req_op2 = 3'd0; req_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports.
        #1;
        check_rd(32'h0, 1);
        check_resp(1'b0, 1'b0, 7'h00, 1'b0, 1);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i]);
        end

        // R8: no outcome without req_valid, even with a decodable request.
        req_cp = 4'd15; req_priv = 1'b1; req_crn = 4'd13; req_crm = 4'd0; req_write = 1'b1;
        #1;
        check_resp(1'b0, 1'b0, 7'h00, 1'b0, 8);
        req_write = 1'b0;
        @(negedge clk);

        // R11: grant coprocessor 4, then R1: reset locks it again.
        run_op('{1'b1, 4'd15, 1'b1, 4'd15, 4'd1, 3'd0, 32'h0000_0010, 1'b1, 1'b0, 7'h01, 1'b0, 1'b0, 32'h0, 8'd11});
        run_op('{1'b0, 4'd4,  1'b0, 4'd0,  4'd0, 3'd0, 32'h0,         1'b1, 1'b0, 7'h00, 1'b0, 1'b0, 32'h0, 8'd11});
        run_op('{1'b0, 4'd15, 1'b1, 4'd14, 4'd9, 3'd0, 32'h0,         1'b1, 1'b0, 7'h08, 1'b0, 1'b1, 32'hAAAA_5555, 8'd5});
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_rd(32'h0, 1);  // R1 rd_data cleared
        @(negedge clk);
        run_op('{1'b0, 4'd4,  1'b0, 4'd0,  4'd0, 3'd0, 32'h0, 1'b0, 1'b1, 7'h00, 1'b0, 1'b0, 32'h0, 8'd1});
        run_op('{1'b0, 4'd15, 1'b1, 4'd14, 4'd9, 3'd0, 32'h0, 1'b1, 1'b0, 7'h08, 1'b0, 1'b1, 32'h0, 8'd1});
        run_op('{1'b0, 4'd15, 1'b1, 4'd13, 4'd0, 3'd0, 32'h0, 1'b1, 1'b0, 7'h02, 1'b0, 1'b1, 32'h0, 8'd1});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule